// File: doc/BRIEF.md
# Sequential Booth Multiplier

This block multiplies two signed two's complement operands of `W` bits each and returns their full `2W`-bit signed product. It uses radix-2 Booth recoding over an iterative datapath. An accumulator, a multiplier shift register, one appended low-order bit and a held copy of the multiplicand are updated together, one recoding step per clock. A run takes `W` steps.

Each step looks at a two-bit window: the multiplier register's least significant bit, plus the bit that was shifted out of it on the step before. From that window the step subtracts the multiplicand from the accumulator, adds it, or leaves the accumulator alone. The accumulator, the multiplier register and the appended bit then shift right by one place as a single arithmetic unit, so the sign is kept. After the last step, the upper half of the product sits in the accumulator and the lower half sits in the multiplier register. The appended bit is not part of the result.

A caller pulses `start_i` while the block is idle, with both operands valid in that cycle. `done_o` then marks the cycle in which `product_o` is final. The product stays on the output until the next accepted start.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset and before the first accepted start, `product_o` is all zeros and `done_o` is low.
- R2: When `start_i` is sampled high on a rising edge while the block is idle, `done_o` goes high exactly `W` rising edges later. It stays high for one cycle only and is low in every cycle between the start and that edge.
- R3: In the cycle `done_o` is high, `product_o` holds the two's complement product of the operands captured at the accepted start (`mcand_i` times `mplier_i`, both signed, result `2W` bits wide).
- R4: The most negative operand is handled in every combination. With `W`=8, -128 times -128 gives 16384 (0x4000), and -128 times 127 gives -16256 (0xC080).
- R5: While the block is idle and `start_i` is low, `product_o` does not change.
- R6: A `start_i` pulse that arrives while a multiplication is in progress is ignored. The running result and its `done_o` timing are unchanged.
- R7: A multiplier of all zeros (every window 00) gives 0. A multiplier of all ones (the first window 10, every later window 11) gives the negated multiplicand.
- R8: With `W`=5, -9 times -13 gives the 10-bit product 117 (0b0001110101).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a multiplication; accepted only while idle |
| mcand_i | input | W | Signed multiplicand, sampled at the accepted start |
| mplier_i | input | W | Signed multiplier, sampled at the accepted start |
| product_o | output | 2W | Signed product; final when `done_o` is high and held until the next accepted start |
| done_o | output | 1 | One-cycle pulse marking a final product |

## Verification
An accepted start is the rising edge at which `start_i` is sampled high. The product and the done pulse are due `W` rising edges after it. The bench drives inputs on falling edges and samples on falling edges. After each of those `W` edges it compares `done_o` against the expected pulse position, so the pulse must appear after exactly the last edge and at no earlier one. The product is compared in that same done cycle. On the following falling edge, the bench checks that `done_o` has dropped and that the product has not moved. A start pulse injected mid-run must leave both the timing and the value untouched.

// File: rtl/booth_pkg.sv
package booth_pkg;

   typedef enum logic [1:0] {
      BOOTH_KEEP = 2'd0,
      BOOTH_ADD  = 2'd1,
      BOOTH_SUB  = 2'd2
   } booth_op_e;

   // Counter width for a run of n steps
   function automatic int unsigned step_cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
   import booth_pkg::*;
(
   input  logic      q_lsb_i,
   input  logic      q_ext_i,
   output booth_op_e op_o
);

   always_comb begin
      unique case ({q_lsb_i, q_ext_i})
         2'b10:   op_o = BOOTH_SUB;   // first one of a run of ones
         2'b01:   op_o = BOOTH_ADD;   // first zero after a run of ones
         default: op_o = BOOTH_KEEP;  // inside a run
      endcase
   end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
   import booth_pkg::*;
#(
   parameter int unsigned AW           = 9,
   parameter bit          SHARED_ADDER = 1'b1
)(
   input  logic [AW-1:0] acc_i,
   input  logic [AW-1:0] opd_i,
   input  booth_op_e     op_i,
   output logic [AW-1:0] res_o
);

   generate
      if (SHARED_ADDER) begin : g_shared
         // One carry chain; subtraction through inverted operand and carry-in
         logic          is_sub;
         logic [AW-1:0] opd_sel;
         logic [AW-1:0] sum;
         assign is_sub  = (op_i == BOOTH_SUB);
         assign opd_sel = is_sub ? ~opd_i : opd_i;
         assign sum     = acc_i + opd_sel + {{(AW-1){1'b0}}, is_sub};
         assign res_o   = (op_i == BOOTH_KEEP) ? acc_i : sum;
      end else begin : g_split
         // Separate add and subtract paths, selected after the carry chains
         logic [AW-1:0] sum;
         logic [AW-1:0] diff;
         assign sum  = acc_i + opd_i;
         assign diff = acc_i - opd_i;
         always_comb begin
            unique case (op_i)
               BOOTH_ADD: res_o = sum;
               BOOTH_SUB: res_o = diff;
               default:   res_o = acc_i;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl
   import booth_pkg::*;
#(
   parameter int unsigned W = 8
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic done_o
);

   localparam int unsigned CW = step_cnt_bits(W);
   localparam logic [CW-1:0] CNT_INIT = CW'(W);
   localparam logic [CW-1:0] CNT_LAST = CW'(1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          done_q;
   logic          last_step;

   assign load_o    = start_i && !busy_q;
   assign step_o    = busy_q;
   assign last_step = busy_q && (cnt_q == CNT_LAST);
   assign done_o    = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= last_step;
         if (load_o) begin
            cnt_q  <= CNT_INIT;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            cnt_q <= cnt_q - CNT_LAST;
            if (last_step) busy_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
   import booth_pkg::*;
#(
   parameter int unsigned W            = 8,
   parameter bit          SHARED_ADDER = 1'b1
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [W-1:0]   mcand_i,
   input  logic [W-1:0]   mplier_i,
   output logic [2*W-1:0] product_o,
   output logic           done_o
);

   // One guard bit keeps the accumulator sign right when the most negative
   // multiplicand is subtracted.
   localparam int unsigned AW = W + 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("booth_seq_mul: W must be at least 2");
      end
   endgenerate

   logic [AW-1:0] ac_q;
   logic [W-1:0]  qr_q;
   logic          qx_q;
   logic [AW-1:0] br_q;
   logic [AW-1:0] ac_next;
   booth_op_e     op;
   logic          load;
   logic          step;

   booth_seq_ctrl #(.W(W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .load_o  (load),
      .step_o  (step),
      .done_o  (done_o)
   );

   booth_recode u_recode (
      .q_lsb_i (qr_q[0]),
      .q_ext_i (qx_q),
      .op_o    (op)
   );

   booth_addsub #(.AW(AW), .SHARED_ADDER(SHARED_ADDER)) u_addsub (
      .acc_i (ac_q),
      .opd_i (br_q),
      .op_i  (op),
      .res_o (ac_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac_q <= '0;
         qr_q <= '0;
         qx_q <= 1'b0;
         br_q <= '0;
      end else if (load) begin
         ac_q <= '0;
         qr_q <= mplier_i;
         qx_q <= 1'b0;
         br_q <= {mcand_i[W-1], mcand_i};
      end else if (step) begin
         // arithmetic right shift of {AC, QR, Qx} after the add/subtract
         {ac_q, qr_q, qx_q} <= {ac_next[AW-1], ac_next, qr_q};
      end
   end

   assign product_o = {ac_q[W-1:0], qr_q};

endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
   parameter int unsigned W = 8
)(
   input logic           clk,
   input logic           rst_n,
   input logic           start_i,
   input logic [W-1:0]   mcand_i,
   input logic [W-1:0]   mplier_i,
   input logic [2*W-1:0] product_o,
   input logic           done_o
);

   localparam int unsigned AGW = $clog2(W + 2);

   logic                  run_q;
   logic                  seen_q;
   logic [AGW-1:0]        age_q;
   logic [W-1:0]          a_q;
   logic [W-1:0]          b_q;
   logic                  accept;
   logic signed [2*W-1:0] expect_prod;

   assign accept = start_i && !run_q;
   assign expect_prod = $signed({{W{a_q[W-1]}}, a_q}) * $signed({{W{b_q[W-1]}}, b_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         seen_q <= 1'b0;
         age_q  <= '0;
         a_q    <= '0;
         b_q    <= '0;
      end else if (accept) begin
         run_q  <= 1'b1;
         seen_q <= 1'b1;
         age_q  <= '0;
         a_q    <= mcand_i;
         b_q    <= mplier_i;
      end else if (run_q) begin
         age_q <= age_q + 1'b1;
         if (done_o) run_q <= 1'b0;
      end
   end

   assert_idle_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen_q) |-> (product_o == '0 && !done_o));

   assert_done_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (run_q && age_q == AGW'(W)));

   assert_no_early_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && age_q < AGW'(W)) |-> !done_o);

   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($signed(product_o) == expect_prod));

   assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !start_i) |=> $stable(product_o));

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .mcand_i   (mcand_i),
   .mplier_i  (mplier_i),
   .product_o (product_o),
   .done_o    (done_o)
);

// File: tb/tb_booth_seq_mul.sv
module tb_booth_seq_mul;

   localparam int unsigned W  = 8;
   localparam int unsigned W5 = 5;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [W-1:0]   mcand = '0;
   logic [W-1:0]   mplier = '0;
   logic [2*W-1:0] product;
   logic           done;

   logic            start5 = 1'b0;
   logic [W5-1:0]   mcand5 = '0;
   logic [W5-1:0]   mplier5 = '0;
   logic [2*W5-1:0] product5;
   logic            done5;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   booth_seq_mul #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .mcand_i(mcand), .mplier_i(mplier),
      .product_o(product), .done_o(done)
   );

   booth_seq_mul #(.W(W5), .SHARED_ADDER(1'b0)) dut_n5 (
      .clk(clk), .rst_n(rst_n), .start_i(start5),
      .mcand_i(mcand5), .mplier_i(mplier5),
      .product_o(product5), .done_o(done5)
   );

   function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      logic signed [2*W-1:0] sa;
      logic signed [2*W-1:0] sb;
      sa = $signed({{W{a[W-1]}}, a});
      sb = $signed({{W{b[W-1]}}, b});
      return sa * sb;
   endfunction

   task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                        input logic [2*W-1:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // poke: raise start with other operands mid-run (R6)
   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit poke, input string req);
      logic [2*W-1:0] exp;
      int bad_cycle;
      exp = ref_mul(a, b);
      bad_cycle = -1;
      @(negedge clk);
      start = 1'b1; mcand = a; mplier = b;
      @(negedge clk);                      // accept edge has passed
      start = 1'b0; mcand = ~a; mplier = a ^ b;
      if (done) bad_cycle = 0;
      for (int i = 1; i <= int'(W); i++) begin
         @(negedge clk);
         start = 1'b0;
         if (done != (i == int'(W)) && bad_cycle < 0) bad_cycle = i;
         if (poke && i == 2) begin
            start = 1'b1; mcand = 8'h5A; mplier = 8'hC3;
         end
      end
      check(bad_cycle < 0, "R2 done timing", 16'(bad_cycle), 16'(W));
      check(product == exp, req, product, exp);
      @(negedge clk);
      check(!done, "R2 one-cycle done", {15'd0, done}, 16'd0);
      check(product == exp, "R5 product held", product, exp);
   endtask

   initial begin : watchdog
      repeat (60000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      check(product == '0 && !done, "R1 reset state", product, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(product == '0 && !done, "R1 idle after reset", product, '0);

      // directed corners
      run_op(8'd3, 8'd5, 1'b0, "R3 small positive");
      run_op(8'h80, 8'h80, 1'b0, "R4 min x min");
      check(product == 16'h4000, "R4 min x min value", product, 16'h4000);
      run_op(8'h80, 8'h7F, 1'b0, "R4 min x max");
      check(product == 16'hC080, "R4 min x max value", product, 16'hC080);
      run_op(8'h7F, 8'h80, 1'b0, "R4 max x min");
      run_op(8'h80, 8'hFF, 1'b0, "R4 min x -1");
      run_op(8'h25, 8'h00, 1'b0, "R7 multiplier zero");
      run_op(8'h25, 8'hFF, 1'b0, "R7 multiplier all ones");
      check(product == 16'hFFDB, "R7 negated multiplicand", product, 16'hFFDB);
      run_op(8'hF7, 8'hF3, 1'b0, "R3 -9 x -13");
      run_op(8'h55, 8'hAA, 1'b0, "R3 alternating bits");
      run_op(8'h6B, 8'hD2, 1'b1, "R6 start ignored while busy");

      // R5: idle gap with start low, product must not move
      begin
         logic [2*W-1:0] held;
         held = product;
         mcand = 8'h11; mplier = 8'h22;
         repeat (4) @(negedge clk);
         check(product == held, "R5 idle inputs ignored", product, held);
      end

      // random operands
      for (int n = 0; n < 300; n++) begin
         logic [W-1:0] a;
         logic [W-1:0] b;
         a = W'($urandom);
         b = W'($urandom);
         run_op(a, b, (n % 17) == 0, "R3 random");
         repeat ($urandom_range(0, 2)) @(negedge clk);
      end

      // R8: five-bit instance, -9 x -13
      @(negedge clk);
      start5 = 1'b1; mcand5 = 5'b10111; mplier5 = 5'b10011;
      @(negedge clk);
      start5 = 1'b0;
      repeat (W5 - 1) @(negedge clk);
      check(!done5, "R8 done not yet", {15'd0, done5}, 16'd0);
      @(negedge clk);
      check(done5, "R8 done after five steps", {15'd0, done5}, 16'd1);
      check(product5 == 10'd117, "R8 five-bit product",
            {6'd0, product5}, 16'd117);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule